// File: doc/BRIEF.md
# Event Timer Register Front End

This block is the software-visible face of a multi-channel event timer. A 32-bit bus reaches a capability word, a global control word, an interrupt status word, a 64-bit free-running main counter, and a window of registers for each timer channel. Every 64-bit quantity is reached as a low word and a high word four bytes above it. The block holds each channel's configuration, comparator and route values, and it drives them out with one-cycle write strobes to the comparator and interrupt blocks that sit beside it.

The main counter is run by a two-state machine. In `CNT_HALTED` the count holds still and software may load either half of it. In `CNT_RUNNING` it advances by one tick per clock and ignores loads. The `T_START` transition (HALTED to RUNNING) happens when a control write sets the enable bit. It pulses `ch_arm` for every channel whose comparator is not all ones. The `T_STOP` transition (RUNNING to HALTED) happens when a control write clears the enable bit. It pulses `ch_disarm` for every channel. Reads return data on the cycle after the request, together with `bus_rvalid`.

Top module: `evt_regfile`

## Requirements
- R1: After reset the counter reads 0, the machine is in `CNT_HALTED`, both control bits are 0, every comparator holds all ones, every channel configuration holds 0, and `bus_rvalid` is low.
- R2: The capability low word at 0x000 is {vendor[15:0] in bits 31:16, bit 15 = 1 (legacy routing capable), bit 14 = 0, bit 13 = 1 (64-bit counter), channels minus one in bits 12:8, revision in bits 7:0}. The high word at 0x004 is the tick period in femtoseconds.
- R3: A read request returns its data with `bus_rvalid` on the following cycle. Unmapped offsets and the windows of channels that do not exist read 0, and writes to them change nothing and raise no strobe.
- R4: In `CNT_RUNNING` the counter rises by exactly one per clock. A read returns the live count.
- R5: In `CNT_HALTED` the counter holds its value, and writes to 0x0F0 (low) or 0x0F4 (high) load it. Counter writes in `CNT_RUNNING` are ignored.
- R6: A control write that sets bit 0 while halted (`T_START`) pulses `ch_arm` for one cycle, on the cycle after the write. The pulse is raised only for channels whose comparator is not all ones.
- R7: A control write that clears bit 0 while running (`T_STOP`) pulses `ch_disarm` for one cycle on every channel. The count taken on that write's clock edge is the last one.
- R8: The global control word at 0x010 keeps bit 0 (enable) and bit 1 (legacy mode). Its other bits read 0, and its high word at 0x014 reads 0.
- R9: Channel n's configuration low word at 0x100+0x20*n stores only the bits of mask 0x7F4E and always reads bits 4 and 5 as 1. The high word at +4 reads the route-capability parameter, and writes to it are ignored.
- R10: Each channel's comparator sits at +0x08/+0x0C and its route at +0x10/+0x14. Writes to the configuration low word, the comparator and the route each pulse their own per-channel strobe on the cycle after the write.
- R11: The status word at 0x020 reads `ch_status`. Writing it pulses `sts_clr` on the next cycle for the bits that are 1 in both the written data and `ch_status`.
- R12: The requested channel count is clamped to the range 3 to 24, and the capability field reports the clamped count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of a 32-bit word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid when bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after the request |
| ch_status | input | NUM_CH | Per-channel interrupt status from the channel blocks |
| sts_clr | output | NUM_CH | One-cycle status clear strobes |
| cnt_value | output | 64 | Main counter |
| cnt_running | output | 1 | Machine is in CNT_RUNNING |
| legacy_mode | output | 1 | Legacy routing control bit |
| ch_cfg | output | NUM_CH*32 | Stored channel configuration words |
| ch_cmp | output | NUM_CH*64 | Channel comparators |
| ch_route | output | NUM_CH*64 | Channel route words |
| ch_cfg_wr | output | NUM_CH | Configuration write strobes |
| ch_cmp_wr | output | NUM_CH | Comparator write strobes |
| ch_route_wr | output | NUM_CH | Route write strobes |
| ch_arm | output | NUM_CH | Re-arm pulse on T_START |
| ch_disarm | output | NUM_CH | Disarm pulse on T_STOP |

## Verification
The checker watches the counter on every cycle. While running it must advance by exactly one, and while halted it must hold unless a counter write arrives. It also checks that arm and disarm pulses appear only on the cycle right after the machine changes state, that a disarm pulse covers every channel, and that `bus_rvalid` answers each read and nothing else. The bench scenarios show what a property cannot: the exact field layout of the capability and configuration words, the write masks, that writes to absent channels and read-only halves have no effect, that the arm pulse skips channels whose comparator is all ones, that the frozen count is exact after a one-cycle run, and that the channel count is clamped at both ends.

// File: rtl/evt_pkg.sv
package evt_pkg;

    localparam int MIN_CH   = 3;
    localparam int MAX_CH   = 24;
    localparam int DATA_W   = 32;
    localparam int CH_IDX_W = 5;

    localparam int OFS_CAP_LO = 'h000;
    localparam int OFS_CAP_HI = 'h004;
    localparam int OFS_CFG_LO = 'h010;
    localparam int OFS_CFG_HI = 'h014;
    localparam int OFS_STS    = 'h020;
    localparam int OFS_CNT_LO = 'h0F0;
    localparam int OFS_CNT_HI = 'h0F4;
    localparam int CH_BASE    = 'h100;
    localparam int CH_STRIDE_LG = 5;

    function automatic int clamp_ch(input int n);
        if (n < MIN_CH) return MIN_CH;
        if (n > MAX_CH) return MAX_CH;
        return n;
    endfunction

    typedef enum logic [2:0] {
        CR_NONE, CR_CFG_LO, CR_CFG_HI, CR_CMP_LO, CR_CMP_HI, CR_RT_LO, CR_RT_HI
    } chreg_e;

    typedef enum logic [2:0] {
        GR_NONE, GR_CAP_LO, GR_CAP_HI, GR_CFG_LO, GR_CFG_HI, GR_STS, GR_CNT_LO, GR_CNT_HI
    } glbreg_e;

    typedef struct packed {
        glbreg_e              greg;
        chreg_e               creg;
        logic [CH_IDX_W-1:0]  ch_idx;
        logic                 ch_hit;
    } dec_t;

    typedef enum logic {
        CNT_HALTED,
        CNT_RUNNING
    } cnt_state_e;

endpackage

// File: rtl/evt_addr_dec.sv
module evt_addr_dec #(
    parameter int ADDR_W = 10,
    parameter int NUM_CH = 3
) (
    input  logic [ADDR_W-1:0] addr,
    output evt_pkg::dec_t     dec
);
    import evt_pkg::*;

    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(CH_BASE);

    logic [ADDR_W-1:0] rel;
    logic              in_win;

    always_comb begin
        rel    = addr - BASE;
        in_win = (addr >= BASE);
        dec    = '{greg: GR_NONE, creg: CR_NONE, ch_idx: '0, ch_hit: 1'b0};
        if (in_win) begin
            dec.ch_idx = CH_IDX_W'(rel >> CH_STRIDE_LG);
            dec.ch_hit = ((rel >> CH_STRIDE_LG) < ADDR_W'(NUM_CH));
            case (rel[CH_STRIDE_LG-1:0])
                5'h00:   dec.creg = CR_CFG_LO;
                5'h04:   dec.creg = CR_CFG_HI;
                5'h08:   dec.creg = CR_CMP_LO;
                5'h0C:   dec.creg = CR_CMP_HI;
                5'h10:   dec.creg = CR_RT_LO;
                5'h14:   dec.creg = CR_RT_HI;
                default: dec.creg = CR_NONE;
            endcase
            if (!dec.ch_hit) dec.creg = CR_NONE;
        end else begin
            case (addr)
                ADDR_W'(OFS_CAP_LO): dec.greg = GR_CAP_LO;
                ADDR_W'(OFS_CAP_HI): dec.greg = GR_CAP_HI;
                ADDR_W'(OFS_CFG_LO): dec.greg = GR_CFG_LO;
                ADDR_W'(OFS_CFG_HI): dec.greg = GR_CFG_HI;
                ADDR_W'(OFS_STS):    dec.greg = GR_STS;
                ADDR_W'(OFS_CNT_LO): dec.greg = GR_CNT_LO;
                ADDR_W'(OFS_CNT_HI): dec.greg = GR_CNT_HI;
                default:             dec.greg = GR_NONE;
            endcase
        end
    end

endmodule

// File: rtl/evt_main_counter.sv
module evt_main_counter #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic              en_bit,
    input  logic              leg_bit,
    input  logic              cnt_wr_lo,
    input  logic              cnt_wr_hi,
    input  logic [DATA_W-1:0] wdata,
    output logic [CNT_W-1:0]  count,
    output logic              running,
    output logic              legacy,
    output logic              arm_evt,
    output logic              disarm_evt
);
    import evt_pkg::*;

    localparam int HALF = CNT_W / 2;

    cnt_state_e state, state_nx;
    logic       t_start, t_stop;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CNT_HALTED;
        else        state <= state_nx;
    end

    // transitions: T_START (HALTED->RUNNING), T_STOP (RUNNING->HALTED)
    always_comb begin
        state_nx = state;
        t_start  = 1'b0;
        t_stop   = 1'b0;
        unique case (state)
            CNT_HALTED: if (ctl_wr && en_bit) begin
                state_nx = CNT_RUNNING;
                t_start  = 1'b1;
            end
            CNT_RUNNING: if (ctl_wr && !en_bit) begin
                state_nx = CNT_HALTED;
                t_stop   = 1'b1;
            end
        endcase
    end

    // counter datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (state == CNT_RUNNING) begin
            count <= count + CNT_W'(1);
        end else if (cnt_wr_lo) begin
            count[HALF-1:0] <= HALF'(wdata);
        end else if (cnt_wr_hi) begin
            count[CNT_W-1:HALF] <= HALF'(wdata);
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arm_evt    <= 1'b0;
            disarm_evt <= 1'b0;
            legacy     <= 1'b0;
        end else begin
            arm_evt    <= t_start;
            disarm_evt <= t_stop;
            if (ctl_wr) legacy <= leg_bit;
        end
    end

    assign running = (state == CNT_RUNNING);

endmodule

// File: rtl/evt_chan_regs.sv
module evt_chan_regs #(
    parameter int          DATA_W    = 32,
    parameter logic [31:0] CFG_WMASK = 32'h0000_7F4E
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  evt_pkg::chreg_e      creg,
    input  logic [DATA_W-1:0]    wdata,
    input  logic                 arm_evt,
    input  logic                 disarm_evt,
    output logic [DATA_W-1:0]    cfg,
    output logic [2*DATA_W-1:0]  cmp,
    output logic [2*DATA_W-1:0]  route,
    output logic                 cfg_wr,
    output logic                 cmp_wr,
    output logic                 route_wr,
    output logic                 arm,
    output logic                 disarm
);
    import evt_pkg::*;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg      <= '0;
            cmp      <= '1;
            route    <= '0;
            cfg_wr   <= 1'b0;
            cmp_wr   <= 1'b0;
            route_wr <= 1'b0;
        end else begin
            cfg_wr   <= wr_en && (creg == CR_CFG_LO);
            cmp_wr   <= wr_en && (creg == CR_CMP_LO || creg == CR_CMP_HI);
            route_wr <= wr_en && (creg == CR_RT_LO || creg == CR_RT_HI);
            if (wr_en) begin
                case (creg)
                    CR_CFG_LO: cfg                     <= wdata & CFG_WMASK;
                    CR_CMP_LO: cmp[DATA_W-1:0]         <= wdata;
                    CR_CMP_HI: cmp[2*DATA_W-1:DATA_W]  <= wdata;
                    CR_RT_LO:  route[DATA_W-1:0]       <= wdata;
                    CR_RT_HI:  route[2*DATA_W-1:DATA_W] <= wdata;
                    default: ;
                endcase
            end
        end
    end

    assign arm    = arm_evt && (cmp != '1);
    assign disarm = disarm_evt;

endmodule

// File: rtl/evt_regfile.sv
module evt_regfile #(
    parameter int          ADDR_W     = 10,
    parameter int          NUM_CH_REQ = 3,
    parameter logic [15:0] VENDOR     = 16'h5A17,
    parameter logic [7:0]  REVISION   = 8'h01,
    parameter logic [31:0] TICK_FS    = 32'd10_000_000,
    parameter logic [31:0] ROUTE_CAP  = 32'h00C0_0000,
    parameter logic [31:0] CFG_WMASK  = 32'h0000_7F4E,
    parameter logic [31:0] CFG_FIXED  = 32'h0000_0030,
    localparam int         NUM_CH     = evt_pkg::clamp_ch(NUM_CH_REQ),
    localparam int         DW         = evt_pkg::DATA_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_valid,
    input  logic                 bus_write,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DW-1:0]        bus_wdata,
    output logic [DW-1:0]        bus_rdata,
    output logic                 bus_rvalid,
    input  logic [NUM_CH-1:0]    ch_status,
    output logic [NUM_CH-1:0]    sts_clr,
    output logic [2*DW-1:0]      cnt_value,
    output logic                 cnt_running,
    output logic                 legacy_mode,
    output logic [NUM_CH*DW-1:0]   ch_cfg,
    output logic [NUM_CH*2*DW-1:0] ch_cmp,
    output logic [NUM_CH*2*DW-1:0] ch_route,
    output logic [NUM_CH-1:0]    ch_cfg_wr,
    output logic [NUM_CH-1:0]    ch_cmp_wr,
    output logic [NUM_CH-1:0]    ch_route_wr,
    output logic [NUM_CH-1:0]    ch_arm,
    output logic [NUM_CH-1:0]    ch_disarm
);
    import evt_pkg::*;

    localparam logic [DW-1:0] CAP_LO =
        {VENDOR, 1'b1, 1'b0, 1'b1, 5'(NUM_CH - 1), REVISION};

    dec_t  dec;
    logic  wr_any, rd_any;
    logic  arm_evt, disarm_evt;
    logic [DW-1:0]   rd_mux;
    logic [DW-1:0]   cfg_q   [NUM_CH];
    logic [2*DW-1:0] cmp_q   [NUM_CH];
    logic [2*DW-1:0] route_q [NUM_CH];

    assign wr_any = bus_valid && bus_write;
    assign rd_any = bus_valid && !bus_write;

    evt_addr_dec #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) u_dec (
        .addr (bus_addr),
        .dec  (dec)
    );

    evt_main_counter #(.DATA_W(DW), .CNT_W(2*DW)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_wr     (wr_any && dec.greg == GR_CFG_LO),
        .en_bit     (bus_wdata[0]),
        .leg_bit    (bus_wdata[1]),
        .cnt_wr_lo  (wr_any && dec.greg == GR_CNT_LO),
        .cnt_wr_hi  (wr_any && dec.greg == GR_CNT_HI),
        .wdata      (bus_wdata),
        .count      (cnt_value),
        .running    (cnt_running),
        .legacy     (legacy_mode),
        .arm_evt    (arm_evt),
        .disarm_evt (disarm_evt)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        evt_chan_regs #(.DATA_W(DW), .CFG_WMASK(CFG_WMASK)) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_en      (wr_any && dec.ch_hit && dec.ch_idx == CH_IDX_W'(g)),
            .creg       (dec.creg),
            .wdata      (bus_wdata),
            .arm_evt    (arm_evt),
            .disarm_evt (disarm_evt),
            .cfg        (cfg_q[g]),
            .cmp        (cmp_q[g]),
            .route      (route_q[g]),
            .cfg_wr     (ch_cfg_wr[g]),
            .cmp_wr     (ch_cmp_wr[g]),
            .route_wr   (ch_route_wr[g]),
            .arm        (ch_arm[g]),
            .disarm     (ch_disarm[g])
        );
        assign ch_cfg[g*DW +: DW]         = cfg_q[g];
        assign ch_cmp[g*2*DW +: 2*DW]     = cmp_q[g];
        assign ch_route[g*2*DW +: 2*DW]   = route_q[g];
    end

    always_comb begin
        rd_mux = '0;
        case (dec.greg)
            GR_CAP_LO: rd_mux = CAP_LO;
            GR_CAP_HI: rd_mux = TICK_FS;
            GR_CFG_LO: rd_mux = {{(DW-2){1'b0}}, legacy_mode, cnt_running};
            GR_STS:    rd_mux = DW'(ch_status);
            GR_CNT_LO: rd_mux = cnt_value[DW-1:0];
            GR_CNT_HI: rd_mux = cnt_value[2*DW-1:DW];
            default:   rd_mux = '0;
        endcase
        for (int i = 0; i < NUM_CH; i++) begin
            if (dec.ch_hit && dec.ch_idx == CH_IDX_W'(i)) begin
                case (dec.creg)
                    CR_CFG_LO: rd_mux = cfg_q[i] | CFG_FIXED;
                    CR_CFG_HI: rd_mux = ROUTE_CAP;
                    CR_CMP_LO: rd_mux = cmp_q[i][DW-1:0];
                    CR_CMP_HI: rd_mux = cmp_q[i][2*DW-1:DW];
                    CR_RT_LO:  rd_mux = route_q[i][DW-1:0];
                    CR_RT_HI:  rd_mux = route_q[i][2*DW-1:DW];
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
            sts_clr    <= '0;
        end else begin
            bus_rvalid <= rd_any;
            if (rd_any) bus_rdata <= rd_mux;
            sts_clr <= (wr_any && dec.greg == GR_STS) ?
                       (bus_wdata[NUM_CH-1:0] & ch_status) : '0;
        end
    end

endmodule

// File: rtl/evt_regfile_chk.sv
module evt_regfile_chk #(
    parameter int ADDR_W = 10,
    parameter int NUM_CH = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rvalid,
    input logic [63:0]       cnt_value,
    input logic              cnt_running,
    input logic [NUM_CH-1:0] ch_arm,
    input logic [NUM_CH-1:0] ch_disarm
);
    logic cnt_load;
    assign cnt_load = bus_valid && bus_write &&
                      (bus_addr == ADDR_W'('h0F0) || bus_addr == ADDR_W'('h0F4));

    a_r4_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_running |=> (cnt_value == $past(cnt_value) + 64'd1));

    a_r5_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_running && !cnt_load) |=> $stable(cnt_value));

    a_r6_arm_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        (|ch_arm) |-> (cnt_running && !$past(cnt_running)));

    a_r7_disarm_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (|ch_disarm) |-> (!cnt_running && $past(cnt_running)));

    a_r7_disarm_all: assert property (@(posedge clk) disable iff (!rst_n)
        (|ch_disarm) |-> (&ch_disarm));

    a_r3_read_answered: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write) |=> bus_rvalid);

    a_r3_no_spurious_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |-> $past(bus_valid && !bus_write));

endmodule

bind evt_regfile evt_regfile_chk #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_valid   (bus_valid),
    .bus_write   (bus_write),
    .bus_addr    (bus_addr),
    .bus_rvalid  (bus_rvalid),
    .cnt_value   (cnt_value),
    .cnt_running (cnt_running),
    .ch_arm      (ch_arm),
    .ch_disarm   (ch_disarm)
);

// File: tb/tb_evt_regfile.sv
module tb_evt_regfile;

    localparam logic [15:0] VEND  = 16'h5A17;
    localparam logic [7:0]  REV   = 8'h01;
    localparam logic [31:0] TFS   = 32'd10_000_000;
    localparam logic [31:0] RCAP  = 32'h00C0_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata, rdata_big, rdata_small;
    logic        bus_rvalid, rv_big, rv_small;
    logic [2:0]  ch_status = '0;
    logic [2:0]  sts_clr;
    logic [63:0] cnt_value;
    logic        cnt_running, legacy_mode;
    logic [95:0]  ch_cfg;
    logic [191:0] ch_cmp, ch_route;
    logic [2:0]  ch_cfg_wr, ch_cmp_wr, ch_route_wr, ch_arm, ch_disarm;

    int checks = 0;
    int failures = 0;
    logic [31:0] rd, r1, r2;

    always #2 clk = ~clk;

    evt_regfile #(.NUM_CH_REQ(3), .VENDOR(VEND), .REVISION(REV), .TICK_FS(TFS),
                  .ROUTE_CAP(RCAP)) dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .ch_status(ch_status), .sts_clr(sts_clr),
        .cnt_value(cnt_value), .cnt_running(cnt_running), .legacy_mode(legacy_mode),
        .ch_cfg(ch_cfg), .ch_cmp(ch_cmp), .ch_route(ch_route), .ch_cfg_wr(ch_cfg_wr),
        .ch_cmp_wr(ch_cmp_wr), .ch_route_wr(ch_route_wr), .ch_arm(ch_arm),
        .ch_disarm(ch_disarm));

    // clamp above the maximum
    logic [23:0] b_sts, b_w1, b_w2, b_w3, b_w4, b_w5, b_w6;
    logic [63:0] b_cnt;
    logic        b_run, b_leg;
    logic [767:0]  b_cfg;
    logic [1535:0] b_cmp, b_rt;
    evt_regfile #(.NUM_CH_REQ(40), .VENDOR(VEND), .REVISION(REV), .TICK_FS(TFS),
                  .ROUTE_CAP(RCAP)) dut_big (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_big),
        .bus_rvalid(rv_big), .ch_status(24'd0), .sts_clr(b_sts),
        .cnt_value(b_cnt), .cnt_running(b_run), .legacy_mode(b_leg),
        .ch_cfg(b_cfg), .ch_cmp(b_cmp), .ch_route(b_rt), .ch_cfg_wr(b_w1),
        .ch_cmp_wr(b_w2), .ch_route_wr(b_w3), .ch_arm(b_w4), .ch_disarm(b_w5));
    assign b_w6 = b_w1;

    // clamp below the minimum
    logic [2:0]  s_sts, s_w1, s_w2, s_w3, s_w4, s_w5;
    logic [63:0] s_cnt;
    logic        s_run, s_leg;
    logic [95:0]  s_cfg;
    logic [191:0] s_cmp, s_rt;
    evt_regfile #(.NUM_CH_REQ(1), .VENDOR(VEND), .REVISION(REV), .TICK_FS(TFS),
                  .ROUTE_CAP(RCAP)) dut_small (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_small),
        .bus_rvalid(rv_small), .ch_status(3'd0), .sts_clr(s_sts),
        .cnt_value(s_cnt), .cnt_running(s_run), .legacy_mode(s_leg),
        .ch_cfg(s_cfg), .ch_cmp(s_cmp), .ch_route(s_rt), .ch_cfg_wr(s_w1),
        .ch_cmp_wr(s_w2), .ch_route_wr(s_w3), .ch_arm(s_w4), .ch_disarm(s_w5));

    function automatic logic [31:0] exp_cap(input int nch);
        return {VEND, 1'b1, 1'b0, 1'b1, 5'(nch - 1), REV};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // called at a falling edge; returns at the falling edge after the sampling edge
    task automatic bus_wr(input logic [9:0] a, input logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [9:0] a, output logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        d = bus_rdata;
    endtask

    task automatic t_reset();
        chk("R1 rvalid", bus_rvalid, 0);
        chk("R1 counter", cnt_value, 0);
        chk("R1 running", cnt_running, 0);
        chk("R1 legacy", legacy_mode, 0);
        chk("R1 comparator ch2", ch_cmp[191:128], 64'hFFFF_FFFF_FFFF_FFFF);
        chk("R1 cfg stored", ch_cfg, 0);
        bus_rd(10'h108, rd);
        chk("R1 rvalid after read R3", bus_rvalid, 1);
        chk("R1 cmp read", rd, 32'hFFFF_FFFF);
        @(negedge clk);
        chk("R3 rvalid drops", bus_rvalid, 0);
    endtask

    task automatic t_cap();
        bus_rd(10'h000, rd);
        chk("R2 cap low", rd, exp_cap(3));
        chk("R12 cap clamp high", rdata_big, exp_cap(24));
        chk("R12 cap clamp low", rdata_small, exp_cap(3));
        bus_rd(10'h004, rd);
        chk("R2 cap high period", rd, TFS);
    endtask

    task automatic t_global_cfg();
        bus_wr(10'h010, 32'hFFFF_FFFE);
        chk("R8 legacy out", legacy_mode, 1);
        chk("R8 still halted", cnt_running, 0);
        bus_rd(10'h010, rd);
        chk("R8 cfg read", rd, 32'h2);
        bus_rd(10'h014, rd);
        chk("R8 cfg high zero", rd, 0);
        bus_wr(10'h010, 32'h0);
        chk("R8 legacy cleared", legacy_mode, 0);
    endtask

    task automatic t_halted_load();
        bus_wr(10'h0F0, 32'h0000_1234);
        bus_wr(10'h0F4, 32'h0000_0005);
        chk("R5 loaded", cnt_value, 64'h5_0000_1234);
        bus_rd(10'h0F0, r1);
        repeat (5) @(negedge clk);
        bus_rd(10'h0F0, r2);
        chk("R5 frozen low", r1, 32'h1234);
        chk("R5 frozen twice", r2, 32'h1234);
        bus_rd(10'h0F4, rd);
        chk("R5 high read", rd, 32'h5);
    endtask

    task automatic t_channel_regs();
        bus_wr(10'h120, 32'hFFFF_FFFF);
        chk("R10 cfg strobe", ch_cfg_wr, 3'b010);
        chk("R9 cfg stored mask", ch_cfg[63:32], 32'h0000_7F4E);
        @(negedge clk);
        chk("R10 cfg strobe one cycle", ch_cfg_wr, 0);
        bus_rd(10'h120, rd);
        chk("R9 cfg read fixed bits", rd, 32'h0000_7F7E);
        bus_wr(10'h124, 32'h1234_5678);
        chk("R9 cfg high no strobe", ch_cfg_wr, 0);
        bus_rd(10'h124, rd);
        chk("R9 cfg high read only", rd, RCAP);
        bus_wr(10'h108, 32'h50);
        chk("R10 cmp strobe", ch_cmp_wr, 3'b001);
        bus_wr(10'h10C, 32'h0);
        bus_wr(10'h148, 32'h5);
        bus_wr(10'h14C, 32'h0);
        chk("R10 cmp ch0", ch_cmp[63:0], 64'h50);
        chk("R10 cmp ch2", ch_cmp[191:128], 64'h5);
        bus_wr(10'h150, 32'hAAAA_5555);
        chk("R10 route strobe", ch_route_wr, 3'b100);
        bus_wr(10'h154, 32'h0000_00C3);
        chk("R10 route value", ch_route[191:128], 64'h0000_00C3_AAAA_5555);
        bus_rd(10'h154, rd);
        chk("R10 route high read", rd, 32'hC3);
    endtask

    task automatic t_absent();
        bus_wr(10'h168, 32'h7);
        chk("R3 absent channel no strobe", {ch_cmp_wr, ch_cfg_wr, ch_route_wr}, 0);
        bus_rd(10'h168, rd);
        chk("R3 absent channel read", rd, 0);
        bus_wr(10'h080, 32'hFFFF_FFFF);
        bus_rd(10'h080, rd);
        chk("R3 unmapped read", rd, 0);
        chk("R3 unmapped write no effect", {cnt_running, legacy_mode}, 0);
    endtask

    task automatic t_run();
        bus_wr(10'h0F4, 32'h0);
        bus_wr(10'h010, 32'h1);
        chk("R6 arm skips all-ones comparator", ch_arm, 3'b101);
        chk("R4 running", cnt_running, 1);
        @(negedge clk);
        chk("R6 arm one cycle", ch_arm, 0);
        bus_rd(10'h0F0, r1);
        repeat (10) @(negedge clk);
        bus_rd(10'h0F0, r2);
        chk("R4 live count step", r2 - r1, 32'd11);
        bus_wr(10'h0F0, 32'h0);
        bus_rd(10'h0F0, rd);
        chk("R5 write while running ignored", rd > r2, 1);
        bus_wr(10'h010, 32'h0);
        chk("R7 disarm all", ch_disarm, 3'b111);
        chk("R7 halted", cnt_running, 0);
        @(negedge clk);
        chk("R7 disarm one cycle", ch_disarm, 0);
        bus_rd(10'h0F0, r1);
        repeat (4) @(negedge clk);
        bus_rd(10'h0F0, r2);
        chk("R7 frozen after stop", r2, r1);
    endtask

    task automatic t_exact_freeze();
        bus_wr(10'h0F0, 32'h100);
        bus_wr(10'h0F4, 32'h0);
        bus_wr(10'h010, 32'h1);
        bus_wr(10'h010, 32'h0);
        chk("R7 one-cycle run count", cnt_value, 64'h101);
    endtask

    task automatic t_status();
        ch_status = 3'b110;
        bus_rd(10'h020, rd);
        chk("R11 status read", rd, 32'h6);
        bus_wr(10'h020, 32'h3);
        chk("R11 clear strobe", sts_clr, 3'b010);
        @(negedge clk);
        chk("R11 clear one cycle", sts_clr, 0);
        ch_status = 3'b000;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_cap();
        t_global_cfg();
        t_halted_load();
        t_channel_regs();
        t_absent();
        t_run();
        t_exact_freeze();
        t_status();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule